// File: doc/BRIEF.md
# Banked Nibble-Wide Real-Time Clock

This block is a calendar clock reached through a 4-bit register bus. Each bus access uses a 4-bit address and 4-bit data, with separate write and read strobes. A read strobe loads the addressed nibble into a registered read port. The clock keeps seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each value except day of week is stored as a pair of BCD nibbles, one for units and one for tens.

A mode register selects which of four banks appears at the low thirteen addresses. Bank 0 holds the counters. Bank 1 holds the alarm digits, the hour-format select and the leap-year counter. Banks 2 and 3 are two independent 13-nibble scratch RAMs. The mode, test and reset registers sit above the banked range and can be reached from every bank.

A prescaled one-second tick input advances the clock. Software clears timer enable while it reads or sets a consistent group of digits. At most one tick that arrives in that window is kept and applied once counting resumes.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the counters read 00:00:00, day of week 0, day 01, month 01 and year 00. The mode register, test register and leap counter read 0, and the hour format is 24-hour.
- R2: Mode bits [1:0] pick the bank: 00 counters, 01 alarm/configuration, 10 RAM A, 11 RAM B. In bank 00, addresses 0x0 to 0xC hold, in this order: second units, second tens, minute units, minute tens, hour units, hour tens, day of week, day units, day tens, month units, month tens, year units and year tens.
- R3: Address 0xD is the mode register and 0xE is the test register, and both read back in every bank. Address 0xF reads bits [3:2] as last written and bits [1:0] as 0.
- R4: Mode bit 3 enables counting. While it is 0, ticks do not move the counters. At most one held tick is applied once the bit is 1 again.
- R5: Seconds and minutes count in BCD and wrap from 59 to 00, each carrying into the next unit.
- R6: In 24-hour mode (bank 1, address 0xA bit 0 = 1) hours wrap from 23 to 00 and carry into the day.
- R7: In 12-hour mode (address 0xA bit 0 = 0), hour-tens bit 1 is the PM flag (1 = PM) and hour-tens bit 0 is the tens digit. 11 becomes 12 with the flag toggled, and 12 becomes 1. Only 11 PM to 12 AM carries into the day.
- R8: The day wraps to 01 after the last day of the month. February has 29 days when the leap counter (bank 1, address 0xB, bits [1:0]) is 0, and 28 days otherwise. Day of week steps 6 to 0 on each day change.
- R9: Month wraps from 12 to 01 and advances the year, and year wraps from 99 to 00. On each year advance the leap counter increments modulo 4.
- R10: Bank 1 addresses 0x2 to 0x8 hold alarm digits for minute units through day tens, in the same layout as bank 0. When mode bit 2 is set and a tick carries out of the seconds so that the new counters at 0x2 to 0x8 equal the alarm digits, `alarm_pulse` is high for one cycle as the new time appears.
- R11: Writing address 0xF with bit 0 set clears all alarm digits. Writing it with bit 1 set discards any held tick, together with a tick arriving in the same cycle.
- R12: The two RAM banks store 13 nibbles each, independently, at addresses 0x0 to 0xC.
- R13: `rdata` takes the addressed value on the clock edge where `rd_en` is high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| tick_1s | input | 1 | One-cycle pulse per second |
| rdata | output | 4 | Registered read data |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
The counters are loaded just below each rollover boundary and then ticked. The patterns are 23:59:58 on 31 December 99, 28 February with the leap counter at 0 and then at 1, 30 April, and the 12-hour values 11 AM, 12 PM and 11 PM. Together these separate the carry paths from one another and separate a month-length error from a day-wrap error. Ticks sent while counting is stopped, with and without a divider clear, separate "held once" from "dropped" and from "all applied". The alarm is run at a matching time with the enable on and then off, which separates the compare logic from its gate. RAM patterns that differ between the two banks, and reads of 0xD to 0xF in every bank, expose bank aliasing.

// File: rtl/nibble_rtc.sv
module nibble_rtc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic [3:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       tick_1s,
  output logic [3:0] rdata,
  output logic       alarm_pulse
);
  localparam int SLOTS = 13;

  logic [3:0] tm [SLOTS];
  logic [3:0] nt [SLOTS];
  logic [3:0] al [SLOTS];
  logic [3:0] ram0 [SLOTS];
  logic [3:0] ram1 [SLOTS];
  logic [3:0] mode_q, test_q, rd_val, rdata_q;
  logic [1:0] pul_q, leap_q;
  logic       h24_q, pend_q, alarm_q;
  logic       s_c, m_c, h_c, d_c, mo_c;
  logic [7:0] mlen;

  wire div_clr  = wr_en && addr == 4'hF && wdata[1];
  wire tick_eff = mode_q[3] && (tick_1s || pend_q) && !div_clr;
  wire alm_hit  = {nt[8], nt[7], nt[6], nt[5], nt[4], nt[3], nt[2]} ==
                  {al[8], al[7], al[6], al[5], al[4], al[3], al[2]};

  always_comb begin
    case ({tm[10], tm[9]})
      8'h02:                      mlen = (leap_q == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  always_comb begin
    nt = tm;
    s_c = 1'b0; m_c = 1'b0; h_c = 1'b0; d_c = 1'b0; mo_c = 1'b0;
    if (tick_eff) begin
      if (tm[0] != 4'd9) nt[0] = tm[0] + 4'd1;
      else begin
        nt[0] = 4'd0;
        if (tm[1] != 4'd5) nt[1] = tm[1] + 4'd1;
        else begin nt[1] = 4'd0; s_c = 1'b1; end
      end
      if (s_c) begin
        if (tm[2] != 4'd9) nt[2] = tm[2] + 4'd1;
        else begin
          nt[2] = 4'd0;
          if (tm[3] != 4'd5) nt[3] = tm[3] + 4'd1;
          else begin nt[3] = 4'd0; m_c = 1'b1; end
        end
      end
      if (m_c) begin
        if (h24_q) begin
          if (tm[5] == 4'd2 && tm[4] == 4'd3) begin nt[4] = 4'd0; nt[5] = 4'd0; h_c = 1'b1; end
          else if (tm[4] == 4'd9) begin nt[4] = 4'd0; nt[5] = tm[5] + 4'd1; end
          else nt[4] = tm[4] + 4'd1;
        end else begin
          if (tm[5][0] && tm[4] == 4'd1) begin
            nt[4] = 4'd2; nt[5] = {2'b00, ~tm[5][1], 1'b1}; h_c = tm[5][1];
          end else if (tm[5][0] && tm[4] == 4'd2) begin
            nt[4] = 4'd1; nt[5] = {2'b00, tm[5][1], 1'b0};
          end else if (tm[4] == 4'd9) begin
            nt[4] = 4'd0; nt[5] = {2'b00, tm[5][1], 1'b1};
          end else nt[4] = tm[4] + 4'd1;
        end
      end
      if (h_c) begin
        nt[6] = (tm[6] == 4'd6) ? 4'd0 : tm[6] + 4'd1;
        if ({tm[8], tm[7]} == mlen) begin nt[7] = 4'd1; nt[8] = 4'd0; d_c = 1'b1; end
        else if (tm[7] == 4'd9) begin nt[7] = 4'd0; nt[8] = tm[8] + 4'd1; end
        else nt[7] = tm[7] + 4'd1;
      end
      if (d_c) begin
        if (tm[10] == 4'd1 && tm[9] == 4'd2) begin nt[9] = 4'd1; nt[10] = 4'd0; mo_c = 1'b1; end
        else if (tm[9] == 4'd9) begin nt[9] = 4'd0; nt[10] = 4'd1; end
        else nt[9] = tm[9] + 4'd1;
      end
      if (mo_c) begin
        if (tm[11] == 4'd9) begin
          nt[11] = 4'd0;
          nt[12] = (tm[12] == 4'd9) ? 4'd0 : tm[12] + 4'd1;
        end else nt[11] = tm[11] + 4'd1;
      end
    end
  end

  always_comb begin
    rd_val = 4'h0;
    if (addr == 4'hD) rd_val = mode_q;
    else if (addr == 4'hE) rd_val = test_q;
    else if (addr == 4'hF) rd_val = {pul_q, 2'b00};
    else if (addr <= 4'hC) begin
      case (mode_q[1:0])
        2'b00: rd_val = tm[addr];
        2'b01: begin
          if (addr >= 4'h2 && addr <= 4'h8) rd_val = al[addr];
          else if (addr == 4'hA) rd_val = {3'b000, h24_q};
          else if (addr == 4'hB) rd_val = {2'b00, leap_q};
        end
        2'b10: rd_val = ram0[addr];
        default: rd_val = ram1[addr];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        tm[i] <= 4'd0; al[i] <= 4'd0; ram0[i] <= 4'd0; ram1[i] <= 4'd0;
      end
      tm[7] <= 4'd1;
      tm[9] <= 4'd1;
      mode_q <= 4'd0; test_q <= 4'd0; pul_q <= 2'd0; leap_q <= 2'd0;
      h24_q <= 1'b1; pend_q <= 1'b0; alarm_q <= 1'b0; rdata_q <= 4'd0;
    end else begin
      tm <= nt;
      if (mo_c) leap_q <= leap_q + 2'd1;
      pend_q  <= (div_clr || mode_q[3]) ? 1'b0 : (pend_q || tick_1s);
      alarm_q <= mode_q[2] && s_c && alm_hit;
      if (rd_en) rdata_q <= rd_val;
      if (wr_en) begin
        if (addr == 4'hD) mode_q <= wdata;
        else if (addr == 4'hE) test_q <= wdata;
        else if (addr == 4'hF) begin
          pul_q <= wdata[3:2];
          if (wdata[0]) for (int i = 0; i < SLOTS; i++) al[i] <= 4'd0;
        end else if (addr <= 4'hC) begin
          case (mode_q[1:0])
            2'b00: tm[addr] <= wdata;
            2'b01: begin
              if (addr >= 4'h2 && addr <= 4'h8) al[addr] <= wdata;
              else if (addr == 4'hA) h24_q <= wdata[0];
              else if (addr == 4'hB) leap_q <= wdata[1:0];
            end
            2'b10: ram0[addr] <= wdata;
            default: ram1[addr] <= wdata;
          endcase
        end
      end
    end
  end

  assign rdata       = rdata_q;
  assign alarm_pulse = alarm_q;
endmodule

// File: rtl/nibble_rtc_sva.sv
module nibble_rtc_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] addr,
  input logic [3:0] wdata,
  input logic       wr_en,
  input logic       rd_en,
  input logic       tick_1s,
  input logic [3:0] rdata,
  input logic       alarm_pulse,
  input logic [3:0] mode_q,
  input logic       pend_q,
  input logic [3:0] sec1,
  input logic [1:0] leap_q,
  input logic [3:0] alm_min1
);
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_frozen_secs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[3] && !wr_en) |=> $stable(sec1));

  assert_held_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !mode_q[3] && !(wr_en && addr == 4'hF && wdata[1])) |=> pend_q);

  assert_leap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[3] && !wr_en) |=> $stable(leap_q));

  assert_alarm_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(mode_q[2]));

  assert_alarm_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hF && wdata[0]) |=> (alm_min1 == 4'd0));
endmodule

bind nibble_rtc nibble_rtc_sva u_sva (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .tick_1s(tick_1s), .rdata(rdata), .alarm_pulse(alarm_pulse),
  .mode_q(mode_q), .pend_q(pend_q), .sec1(tm[0]), .leap_q(leap_q), .alm_min1(al[2])
);

// File: tb/test_nibble_rtc.sv
module test_nibble_rtc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = 4'd0, wdata = 4'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick_1s = 1'b0;
  logic [3:0] rdata;
  logic       alarm_pulse;

  nibble_rtc i_nibble_rtc (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .tick_1s(tick_1s), .rdata(rdata), .alarm_pulse(alarm_pulse)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit running = 1'b0, done = 1'b0;
  string tag = "R1";

  int mt[13], ma[13], mr0[13], mr1[13];
  int mmode, mtest, mpul, mh24, mleap, mpend, mrd, malarm;

  function automatic int mdays(int m, int lp);
    if (m == 2) return (lp == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int mread(int a);
    if (a == 13) return mmode;
    if (a == 14) return mtest;
    if (a == 15) return mpul * 4;
    case (mmode % 4)
      0: return mt[a];
      1: begin
        if (a >= 2 && a <= 8) return ma[a];
        if (a == 10) return mh24;
        if (a == 11) return mleap;
        return 0;
      end
      2: return mr0[a];
      default: return mr1[a];
    endcase
  endfunction

  task automatic mreset();
    for (int i = 0; i < 13; i++) begin mt[i] = 0; ma[i] = 0; mr0[i] = 0; mr1[i] = 0; end
    mt[7] = 1; mt[9] = 1;
    mmode = 0; mtest = 0; mpul = 0; mh24 = 1; mleap = 0; mpend = 0; mrd = 0; malarm = 0;
  endtask

  task automatic mstep(output bit sc);
    int s, mi, h, pm, d, mo, y;
    bit up_h, up_d;
    sc = 0; up_h = 0; up_d = 0;
    s = mt[1] * 10 + mt[0] + 1;
    if (s == 60) begin s = 0; sc = 1; end
    mt[1] = s / 10; mt[0] = s % 10;
    if (sc) begin
      mi = mt[3] * 10 + mt[2] + 1;
      if (mi == 60) begin mi = 0; up_h = 1; end
      mt[3] = mi / 10; mt[2] = mi % 10;
    end
    if (up_h) begin
      if (mh24 != 0) begin
        h = mt[5] * 10 + mt[4] + 1;
        if (h == 24) begin h = 0; up_d = 1; end
        mt[5] = h / 10; mt[4] = h % 10;
      end else begin
        h = (mt[5] % 2) * 10 + mt[4];
        pm = (mt[5] / 2) % 2;
        if (h == 11) begin h = 12; pm = 1 - pm; up_d = (pm == 0); end
        else if (h == 12) h = 1;
        else h = h + 1;
        mt[5] = pm * 2 + h / 10; mt[4] = h % 10;
      end
    end
    if (up_d) begin
      mt[6] = (mt[6] == 6) ? 0 : (mt[6] + 1) % 16;
      d = mt[8] * 10 + mt[7];
      mo = mt[10] * 10 + mt[9];
      if (d == mdays(mo, mleap)) begin
        d = 1; mo = mo + 1;
        if (mo == 13) begin
          mo = 1;
          y = (mt[12] * 10 + mt[11] + 1) % 100;
          mt[12] = y / 10; mt[11] = y % 10;
          mleap = (mleap + 1) % 4;
        end
      end else d = d + 1;
      mt[8] = d / 10; mt[7] = d % 10;
      mt[10] = mo / 10; mt[9] = mo % 10;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else begin
      bit te, clr, sc, hit;
      int om, a, d;
      om = mmode; a = addr; d = wdata;
      clr = wr_en && a == 15 && d[1];
      te = om[3] && (tick_1s || mpend != 0) && !clr;
      if (rd_en) mrd = mread(a);
      mpend = (clr || om[3]) ? 0 : ((mpend != 0 || tick_1s) ? 1 : 0);
      sc = 0;
      if (te) mstep(sc);
      hit = 1;
      for (int k = 2; k <= 8; k++) if (mt[k] != ma[k]) hit = 0;
      malarm = (om[2] && sc && hit) ? 1 : 0;
      if (wr_en) begin
        if (a == 13) mmode = d;
        else if (a == 14) mtest = d;
        else if (a == 15) begin
          mpul = d / 4;
          if (d[0]) for (int k = 0; k < 13; k++) ma[k] = 0;
        end else if (a <= 12) begin
          case (om % 4)
            0: mt[a] = d;
            1: begin
              if (a >= 2 && a <= 8) ma[a] = d;
              else if (a == 10) mh24 = d % 2;
              else if (a == 11) mleap = d % 4;
            end
            2: mr0[a] = d;
            default: mr1[a] = d;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      n_chk++;
      if (int'(rdata) != mrd) begin
        n_fail++;
        $display("FAIL %s rdata addr=%0d actual=%0d expected=%0d", tag, addr, rdata, mrd);
      end
      n_chk++;
      if (int'(alarm_pulse) != malarm) begin
        n_fail++;
        $display("FAIL %s alarm_pulse actual=%0d expected=%0d", tag, alarm_pulse, malarm);
      end
    end
  end

  task automatic drive(input bit w, input bit r, input int a, input int d, input bit t);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = 4'(a); wdata = 4'(d); tick_1s = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    drive(1, 0, a, d, 0);
  endtask

  task automatic rdall();
    for (int a = 0; a < 16; a++) drive(0, 1, a, 0, 0);
    idle(2);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 1);
    idle(1);
  endtask

  task automatic settime(input int y, input int mo, input int d, input int dw,
                         input int h10, input int h1, input int mi, input int s);
    wr(13, 0);
    wr(0, s % 10); wr(1, s / 10); wr(2, mi % 10); wr(3, mi / 10);
    wr(4, h1); wr(5, h10); wr(6, dw); wr(7, d % 10); wr(8, d / 10);
    wr(9, mo % 10); wr(10, mo / 10); wr(11, y % 10); wr(12, y / 10);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    running = 1'b1;
    tag = "R1 reset state"; rdall();
    tag = "R2 bank select"; wr(13, 1); rdall();
    tag = "R12 ram banks";
    wr(13, 2); for (int a = 0; a < 13; a++) wr(a, a ^ 5);
    wr(13, 3); for (int a = 0; a < 13; a++) wr(a, 15 - a);
    rdall(); wr(13, 2); rdall();
    tag = "R3 fixed regs"; wr(14, 9); wr(15, 12); rdall(); wr(13, 1); rdall(); wr(13, 0); rdall();
    tag = "R5 R6 R8 R9 rollover";
    settime(99, 12, 31, 6, 2, 3, 59, 58); wr(13, 8); ticks(2); rdall();
    wr(13, 9); rdall();
    tag = "R8 feb leap0";
    wr(11, 0); settime(24, 2, 28, 2, 2, 3, 59, 59); wr(13, 8); ticks(1); rdall();
    tag = "R8 feb leap1";
    wr(13, 1); wr(11, 1); settime(25, 2, 28, 2, 2, 3, 59, 59); wr(13, 8); ticks(1); rdall();
    tag = "R8 april end";
    settime(25, 4, 30, 3, 2, 3, 59, 59); wr(13, 8); ticks(1); rdall();
    tag = "R7 12h 11am";
    wr(13, 1); wr(10, 0); settime(25, 5, 10, 1, 1, 1, 59, 59); wr(13, 8); ticks(1); rdall();
    tag = "R7 12h 12pm";
    settime(25, 5, 10, 1, 3, 2, 59, 59); wr(13, 8); ticks(1); rdall();
    tag = "R7 12h 11pm";
    settime(25, 5, 10, 1, 3, 1, 59, 59); wr(13, 8); ticks(1); rdall();
    tag = "R4 hold";
    wr(13, 1); wr(10, 1); settime(25, 5, 10, 1, 0, 9, 5, 5); ticks(3); rdall();
    wr(13, 8); idle(2); rdall();
    tag = "R11 divider clear";
    wr(13, 0); ticks(1); wr(15, 2); wr(13, 8); idle(2); rdall();
    tag = "R10 alarm on";
    wr(13, 1); wr(2, 0); wr(3, 3); wr(4, 0); wr(5, 1); wr(6, 3); wr(7, 5); wr(8, 1);
    settime(24, 6, 15, 3, 1, 0, 29, 59); wr(13, 12); ticks(1); idle(2); rdall();
    tag = "R10 alarm off";
    settime(24, 6, 15, 3, 1, 0, 29, 59); wr(13, 8); ticks(1); idle(2); rdall();
    tag = "R11 alarm clear"; wr(15, 1); wr(13, 9); rdall();
    tag = "R13 read hold"; drive(0, 1, 13, 0, 0); idle(5); wr(13, 8); idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule